// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous DRAM and takes the memory from power-on to an idle state in which it can be used. After a synchronous reset it holds the command pins at no-operation for a fixed settling time. During that time clock enable and the data mask stay high, so the memory's data outputs remain high-impedance. It then closes every row with a precharge-all, loads the mode register and runs a burst of auto-refresh commands. Between commands it inserts no-operation cycles to meet the required row-precharge, refresh-cycle and mode-load gaps. When the last gap has elapsed it raises a done flag. The normal access controller takes over from that point.

All timing is given in clock cycles. The settling time is derived from a clock-frequency parameter, at 200 cycles per MHz. The mode word, the refresh count and the gaps are parameters. A further parameter chooses whether the mode load comes before or after the refresh burst. Both orders are valid for the memory, and the total length of the sequence is the same either way.

Top module: `sdram_init_top`

## Requirements
- R1: After reset is released, the command pins carry only no-operation for exactly WAIT_CYC = 200 × CLK_MHZ cycles, counting from the first cycle after release (cycle 0) through cycle WAIT_CYC-1. The command encoding on {cs_n, ras_n, cas_n, we_n} is: no-operation 0111, precharge 0010, auto-refresh 0001, mode load 0000.
- R2: Clock enable is high in every cycle. Every data-mask bit is high in every cycle before the done flag rises.
- R3: The first command after the wait is a precharge-all on cycle WAIT_CYC, with address bit 10 high and every other address bit low.
- R4: A mode-load command drives MODE_VAL on the address bus with the bank address at zero. The default MODE_VAL is 0x030: bits [2:0] hold burst length code 000 (one word), bit 3 holds burst type 0 (sequential), and bits [6:4] hold CAS latency 3.
- R5: Exactly N_REFRESH auto-refresh commands (default 8) are issued per sequence. They carry an all-zero address and bank.
- R6: With MRS_FIRST=1 the mode load comes before every auto-refresh. With MRS_FIRST=0 it comes after the last auto-refresh.
- R7: Consecutive commands are spaced exactly T_RP cycles after the precharge, T_RC cycles after each auto-refresh and T_MRD cycles after the mode load. Only no-operation is issued in between.
- R8: The done flag rises on cycle WAIT_CYC + T_RP + T_MRD + N_REFRESH × T_RC and then stays high. While it is high, the command pins rest at no-operation and every data-mask bit is low.
- R9: Asserting the synchronous reset at any point, including mid-sequence or after done, clears the done flag, forces no-operation with the data mask high, and restarts the sequence from cycle 0 of the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| sdr_cke | output | 1 | Memory clock enable |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | BA_W | Bank address |
| sdr_addr | output | ADDR_W | Address bus |
| sdr_dqm | output | DQM_W | Data mask per byte lane |
| init_done | output | 1 | High once initialization has completed |

## Verification
The bench builds two copies with CLK_MHZ=1, so the settling wait is only 200 cycles. This lets complete sequences and many restarts fit in a short run. The copies use shortened gaps (T_RP=3, T_RC=7, T_MRD=2) and differ only in MRS_FIRST, so both command orders are compared cycle by cycle against the same computed schedule. Reset is cut in at the precharge cycle, one cycle before done, and at seeded random points, to exercise restarts from every phase.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command encoding as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_PRE,
        PH_MRS,
        PH_REF,
        PH_DONE
    } init_phase_e;

    // One cycle's worth of pin values produced by the command generator
    typedef struct packed {
        sdr_cmd_e    cmd;
        logic        cke;
        logic        mask;
    } pin_bundle_t;

    // Mode word: [2:0] burst length code, [3] burst type, [6:4] CAS latency
    function automatic logic [11:0] build_mode(
        input logic [2:0] bl_code,
        input logic       interleaved,
        input logic [2:0] cas_lat
    );
        return {5'b00000, cas_lat, interleaved, bl_code};
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int WAIT_CYC  = 200,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 8,
    parameter bit MRS_FIRST = 1'b1,
    parameter int TMR_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_W-1:0] tmr,
    output logic             tmr_clear,
    output init_phase_e      phase,
    output logic             issue
);

    localparam int REF_W = $clog2(N_REFRESH + 1);
    localparam logic [TMR_W-1:0] WAIT_LAST = TMR_W'(WAIT_CYC - 1);
    localparam logic [TMR_W-1:0] RP_LAST   = TMR_W'(T_RP - 1);
    localparam logic [TMR_W-1:0] RC_LAST   = TMR_W'(T_RC - 1);
    localparam logic [TMR_W-1:0] MRD_LAST  = TMR_W'(T_MRD - 1);
    localparam logic [REF_W-1:0] REF_LAST  = REF_W'(N_REFRESH - 1);

    init_phase_e      phase_q, phase_d;
    logic [REF_W-1:0] ref_q, ref_d;
    logic [TMR_W-1:0] limit;
    logic             at_end;
    init_phase_e      after_pre, after_mrs, after_ref;

    // Phase ordering chosen at elaboration
    generate
        if (MRS_FIRST) begin : g_mode_first
            assign after_pre = PH_MRS;
            assign after_mrs = PH_REF;
            assign after_ref = PH_DONE;
        end else begin : g_refresh_first
            assign after_pre = PH_REF;
            assign after_ref = PH_MRS;
            assign after_mrs = PH_DONE;
        end
    endgenerate

    always_comb begin
        case (phase_q)
            PH_WAIT: limit = WAIT_LAST;
            PH_PRE:  limit = RP_LAST;
            PH_MRS:  limit = MRD_LAST;
            PH_REF:  limit = RC_LAST;
            default: limit = '0;
        endcase
    end

    assign at_end = (tmr == limit);

    always_comb begin
        phase_d = phase_q;
        ref_d   = ref_q;
        if (at_end) begin
            case (phase_q)
                PH_WAIT: phase_d = PH_PRE;
                PH_PRE:  phase_d = after_pre;
                PH_MRS:  phase_d = after_mrs;
                PH_REF: begin
                    if (ref_q == REF_LAST) begin
                        ref_d   = '0;
                        phase_d = after_ref;
                    end else begin
                        ref_d = ref_q + 1'b1;
                    end
                end
                default: phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WAIT;
            ref_q   <= '0;
        end else begin
            phase_q <= phase_d;
            ref_q   <= ref_d;
        end
    end

    assign tmr_clear = at_end || (phase_q == PH_DONE);
    assign phase     = phase_q;
    assign issue     = (tmr == '0) &&
                       ((phase_q == PH_PRE) || (phase_q == PH_MRS) || (phase_q == PH_REF));

endmodule

// File: rtl/sdram_init_cmdgen.sv
module sdram_init_cmdgen
    import sdram_init_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              BA_W     = 1,
    parameter int              DQM_W    = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
    input  init_phase_e       phase,
    input  logic              issue,
    output pin_bundle_t       pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [DQM_W-1:0]  dqm
);

    localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << 10;

    always_comb begin
        pins.cmd  = CMD_NOP;
        pins.cke  = 1'b1;
        pins.mask = (phase != PH_DONE);
        addr      = '0;
        if (issue) begin
            case (phase)
                PH_PRE: begin
                    pins.cmd = CMD_PRE;
                    addr     = PRE_ALL;
                end
                PH_MRS: begin
                    pins.cmd = CMD_MRS;
                    addr     = MODE_VAL;
                end
                PH_REF: pins.cmd = CMD_REF;
                default: pins.cmd = CMD_NOP;
            endcase
        end
    end

    assign ba  = '0;
    assign dqm = {DQM_W{pins.mask}};

endmodule

// File: rtl/sdram_init_top.sv
module sdram_init_top
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 8,
    parameter bit MRS_FIRST = 1'b1,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 1,
    parameter int DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(build_mode(3'd0, 1'b0, 3'd3))
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sdr_cke,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [BA_W-1:0]   sdr_ba,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic [DQM_W-1:0]  sdr_dqm,
    output logic              init_done
);

    localparam int WAIT_CYC = 200 * CLK_MHZ;
    localparam int MAX_SPAN = max_of(max_of(WAIT_CYC, T_RC), max_of(T_RP, T_MRD));
    localparam int TMR_W    = $clog2(MAX_SPAN + 1);

    logic [TMR_W-1:0] tmr;
    logic             tmr_clear;
    init_phase_e      phase;
    logic             issue;
    pin_bundle_t      pins;

    sdram_init_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .count (tmr)
    );

    sdram_init_seq #(
        .WAIT_CYC  (WAIT_CYC),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .T_MRD     (T_MRD),
        .N_REFRESH (N_REFRESH),
        .MRS_FIRST (MRS_FIRST),
        .TMR_W     (TMR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tmr       (tmr),
        .tmr_clear (tmr_clear),
        .phase     (phase),
        .issue     (issue)
    );

    sdram_init_cmdgen #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .DQM_W    (DQM_W),
        .MODE_VAL (MODE_VAL)
    ) u_cmdgen (
        .phase (phase),
        .issue (issue),
        .pins  (pins),
        .addr  (sdr_addr),
        .ba    (sdr_ba),
        .dqm   (sdr_dqm)
    );

    assign sdr_cke   = pins.cke;
    assign sdr_cs_n  = pins.cmd[3];
    assign sdr_ras_n = pins.cmd[2];
    assign sdr_cas_n = pins.cmd[1];
    assign sdr_we_n  = pins.cmd[0];
    assign init_done = (phase == PH_DONE);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 8,
    parameter bit MRS_FIRST = 1'b1,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 1,
    parameter int DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              sdr_cke,
    input logic              sdr_cs_n,
    input logic              sdr_ras_n,
    input logic              sdr_cas_n,
    input logic              sdr_we_n,
    input logic [BA_W-1:0]   sdr_ba,
    input logic [ADDR_W-1:0] sdr_addr,
    input logic [DQM_W-1:0]  sdr_dqm,
    input logic              init_done
);

    localparam int WAIT_CYC = 200 * CLK_MHZ;
    localparam int WC_W     = $clog2(WAIT_CYC + 1);
    localparam logic [WC_W-1:0] WAIT_END = WC_W'(WAIT_CYC);

    logic [3:0]      cmd;
    logic [WC_W-1:0] wait_cnt;
    logic [7:0]      since;
    logic [3:0]      last_cmd;
    logic            seen_any;
    logic            mrs_seen;
    logic [7:0]      refs;
    logic [7:0]      need;

    assign cmd = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};

    always_comb begin
        case (last_cmd)
            CMD_PRE: need = 8'(T_RP);
            CMD_REF: need = 8'(T_RC);
            CMD_MRS: need = 8'(T_MRD);
            default: need = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            since    <= '0;
            last_cmd <= CMD_NOP;
            seen_any <= 1'b0;
            mrs_seen <= 1'b0;
            refs     <= '0;
        end else begin
            if (wait_cnt < WAIT_END) wait_cnt <= wait_cnt + 1'b1;
            if (cmd != CMD_NOP) begin
                since    <= 8'd1;
                last_cmd <= cmd;
                seen_any <= 1'b1;
            end else if (since != 8'hFF) begin
                since <= since + 1'b1;
            end
            if (cmd == CMD_MRS) mrs_seen <= 1'b1;
            if (cmd == CMD_REF && refs != 8'hFF) refs <= refs + 1'b1;
        end
    end

    assert_wait_nop_R1: assert property (@(posedge clk) disable iff (rst)
        (wait_cnt < WAIT_END) |-> (cmd == CMD_NOP));

    assert_cke_high_R2: assert property (@(posedge clk) disable iff (rst)
        sdr_cke);

    assert_mask_high_R2: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (&sdr_dqm));

    assert_first_is_pre_R3: assert property (@(posedge clk) disable iff (rst)
        ((cmd != CMD_NOP) && !seen_any) |-> (cmd == CMD_PRE));

    assert_pre_a10_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> sdr_addr[10]);

    assert_mode_value_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS) |-> ((sdr_addr == MODE_VAL) && (sdr_ba == '0)));

    assert_refresh_count_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (refs == 8'(N_REFRESH)));

    generate
        if (MRS_FIRST) begin : g_ord_mf
            assert_order_R6: assert property (@(posedge clk) disable iff (rst)
                (cmd == CMD_REF) |-> mrs_seen);
        end else begin : g_ord_rf
            assert_order_R6: assert property (@(posedge clk) disable iff (rst)
                (cmd == CMD_MRS) |-> (refs == 8'(N_REFRESH)));
        end
    endgenerate

    assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
        ((cmd != CMD_NOP) && seen_any) |-> (since >= need));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> ((cmd == CMD_NOP) && (sdr_dqm == '0)));

    assert_reset_restart_R9: assert property (@(posedge clk)
        rst |=> (!init_done && (cmd == CMD_NOP) && (&sdr_dqm)));

endmodule

bind sdram_init_top sdram_init_chk #(
    .CLK_MHZ   (CLK_MHZ),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_MRD     (T_MRD),
    .N_REFRESH (N_REFRESH),
    .MRS_FIRST (MRS_FIRST),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DQM_W     (DQM_W),
    .MODE_VAL  (MODE_VAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sdr_cke   (sdr_cke),
    .sdr_cs_n  (sdr_cs_n),
    .sdr_ras_n (sdr_ras_n),
    .sdr_cas_n (sdr_cas_n),
    .sdr_we_n  (sdr_we_n),
    .sdr_ba    (sdr_ba),
    .sdr_addr  (sdr_addr),
    .sdr_dqm   (sdr_dqm),
    .init_done (init_done)
);

// File: tb/sdram_init_tb.sv
module sdram_init_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int T_RP       = 3;
    localparam int T_RC       = 7;
    localparam int T_MRD      = 2;
    localparam int N_REFRESH  = 8;
    localparam int ADDR_W     = 12;
    localparam int W          = 200 * CLK_MHZ;
    localparam int DONE_AT    = W + T_RP + T_MRD + N_REFRESH * T_RC;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [ADDR_W-1:0] MODE_EXP = 12'h030;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Copy A: mode load first; copy B: refresh burst first
    logic              a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [0:0]        a_ba;
    logic [ADDR_W-1:0] a_addr;
    logic [1:0]        a_dqm;
    logic              b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [0:0]        b_ba;
    logic [ADDR_W-1:0] b_addr;
    logic [1:0]        b_dqm;

    sdram_init_top #(
        .CLK_MHZ(CLK_MHZ), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
        .N_REFRESH(N_REFRESH), .MRS_FIRST(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .sdr_cke(a_cke), .sdr_cs_n(a_cs), .sdr_ras_n(a_ras),
        .sdr_cas_n(a_cas), .sdr_we_n(a_we), .sdr_ba(a_ba), .sdr_addr(a_addr),
        .sdr_dqm(a_dqm), .init_done(a_done)
    );

    sdram_init_top #(
        .CLK_MHZ(CLK_MHZ), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
        .N_REFRESH(N_REFRESH), .MRS_FIRST(1'b0)
    ) dut_b (
        .clk(clk), .rst(rst), .sdr_cke(b_cke), .sdr_cs_n(b_cs), .sdr_ras_n(b_ras),
        .sdr_cas_n(b_cas), .sdr_we_n(b_we), .sdr_ba(b_ba), .sdr_addr(b_addr),
        .sdr_dqm(b_dqm), .init_done(b_done)
    );

    // Expected command on cycle k after reset release
    function automatic logic [3:0] exp_cmd(input int k, input bit mf);
        int t;
        int t2;
        if (k < W) return C_NOP;
        if (k == W) return C_PRE;
        t = k - W - T_RP;
        if (t < 0) return C_NOP;
        if (mf) begin
            if (t == 0) return C_MRS;
            t2 = t - T_MRD;
            if (t2 < 0) return C_NOP;
            if (t2 < N_REFRESH * T_RC) return ((t2 % T_RC) == 0) ? C_REF : C_NOP;
            return C_NOP;
        end else begin
            if (t < N_REFRESH * T_RC) return ((t % T_RC) == 0) ? C_REF : C_NOP;
            t2 = t - N_REFRESH * T_RC;
            return (t2 == 0) ? C_MRS : C_NOP;
        end
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [3:0] c);
        if (c == C_PRE) return 12'h400;
        if (c == C_MRS) return MODE_EXP;
        return '0;
    endfunction

    function automatic string tag_for(input int k, input logic [3:0] c);
        if (k >= DONE_AT) return "R8";
        if (k < W) return "R1";
        if (c == C_PRE) return "R3";
        if (c == C_MRS) return "R4";
        if (c == C_REF) return "R5";
        return "R7";
    endfunction

    task automatic check_one(input int k, input bit mf, input logic cke, input logic [3:0] cmd,
                             input logic [ADDR_W-1:0] addr, input logic [0:0] ba,
                             input logic [1:0] dqm, input logic done);
        logic [3:0]        ec;
        logic [ADDR_W-1:0] ea;
        logic              ed;
        logic [1:0]        em;
        ec = exp_cmd(k, mf);
        ea = exp_addr(ec);
        ed = (k >= DONE_AT);
        em = ed ? 2'b00 : 2'b11;
        checks++;
        if (cmd !== ec || addr !== ea || ba !== 1'b0 || done !== ed || dqm !== em || cke !== 1'b1) begin
            fails++;
            $display("FAIL %s (R2/R6 context, mf=%0d) cycle %0d: cmd=%b addr=%h ba=%b dqm=%b cke=%b done=%b expected cmd=%b addr=%h ba=0 dqm=%b cke=1 done=%b",
                     tag_for(k, ec), mf, k, cmd, addr, ba, dqm, cke, done, ec, ea, em, ed);
        end
    endtask

    task automatic check_reset_state();
        checks++;
        if (a_done !== 1'b0 || b_done !== 1'b0 || {a_cs, a_ras, a_cas, a_we} !== C_NOP ||
            {b_cs, b_ras, b_cas, b_we} !== C_NOP || a_dqm !== 2'b11 || b_dqm !== 2'b11 ||
            a_cke !== 1'b1 || b_cke !== 1'b1) begin
            fails++;
            $display("FAIL R9 reset state: doneA=%b doneB=%b cmdA=%b cmdB=%b dqmA=%b dqmB=%b expected done=0 cmd=0111 dqm=11",
                     a_done, b_done, {a_cs, a_ras, a_cas, a_we}, {b_cs, b_ras, b_cas, b_we}, a_dqm, b_dqm);
        end
    endtask

    // Runs ncyc cycles from release; full runs also check totals and ordering
    task automatic run_seq(input int ncyc, input bit full);
        int refs_a = 0;
        int refs_b = 0;
        int mrs_a = -1;
        int mrs_b = -1;
        int first_ref_a = -1;
        int last_ref_b = -1;
        rst = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            check_one(k, 1'b1, a_cke, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_dqm, a_done);
            check_one(k, 1'b0, b_cke, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_dqm, b_done);
            if ({a_cs, a_ras, a_cas, a_we} == C_REF) begin
                refs_a++;
                if (first_ref_a < 0) first_ref_a = k;
            end
            if ({a_cs, a_ras, a_cas, a_we} == C_MRS) mrs_a = k;
            if ({b_cs, b_ras, b_cas, b_we} == C_REF) begin
                refs_b++;
                last_ref_b = k;
            end
            if ({b_cs, b_ras, b_cas, b_we} == C_MRS) mrs_b = k;
            @(negedge clk);
        end
        if (full) begin
            checks++;
            if (refs_a != N_REFRESH || refs_b != N_REFRESH) begin
                fails++;
                $display("FAIL R5 refresh count: A=%0d B=%0d expected %0d", refs_a, refs_b, N_REFRESH);
            end
            checks++;
            if (!(mrs_a >= 0 && mrs_a < first_ref_a)) begin
                fails++;
                $display("FAIL R6 order mode-first: mrs=%0d first_ref=%0d expected mrs before refresh", mrs_a, first_ref_a);
            end
            checks++;
            if (!(mrs_b > last_ref_b && last_ref_b >= 0)) begin
                fails++;
                $display("FAIL R6 order refresh-first: mrs=%0d last_ref=%0d expected mrs after refresh", mrs_b, last_ref_b);
            end
        end
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_state();
    endtask

    initial begin
        int cuts[5];
        int seed_dummy;
        seed_dummy = $urandom(32'd7391);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        cuts[0] = W + 1;
        cuts[1] = DONE_AT;
        for (int i = 2; i < 5; i++) cuts[i] = 1 + $urandom_range(DONE_AT + 10, 0);
        run_seq(DONE_AT + 20, 1'b1);
        for (int r = 0; r < 5; r++) begin
            run_seq(cuts[r], 1'b0);
            run_seq(DONE_AT + 12, 1'b1);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sequence runs completed");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule